// File: doc/BRIEF.md
# Running-Sum Moving Average Filter

This block smooths a stream of signed samples by reporting the mean of the most recent 2^LOG2_DEPTH accepted values. It does not add up the whole window on every sample. Instead it keeps the window in a circular sample store and holds one running total. Each accepted sample is added to that total. The sample it displaces, which is read from the same slot just before the slot is overwritten, is subtracted. Because the window length is a power of two, the mean is simply the upper bits of the total, which is an arithmetic right shift.

An upstream stage pulses `in_valid` whenever `in_sample` carries a new value. A fixed number of cycles later the filter answers with a single-cycle `out_valid` pulse and an updated `out_avg`. `out_full` tells the consumer whether the window holds only real samples yet. Until it does, the missing slots count as zero. The parameter `PIPE_SPLIT` selects between two adder arrangements. With `PIPE_SPLIT` at 0 there is a single three-operand update. With `PIPE_SPLIT` at 1 the subtract and the add go into separate stages, so only two-input adders are used, at the cost of one extra cycle of latency.

Top module: `mavg_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, `out_avg` and `out_full` to 0, and empties every window slot. The first averages after reset therefore count unfilled slots as zero.
- R2: For each accepted sample, `out_avg` equals floor(S / N), where S is the sum of the last N accepted samples and N = 2^LOG2_DEPTH. The value is rounded toward negative infinity, so a window summing to -1 yields -1.
- R3: While fewer than N samples have been accepted since reset, `out_avg` is the sum of the samples accepted so far, arithmetically shifted right by LOG2_DEPTH.
- R4: `out_full` is 0 until the result for the N-th accepted sample since reset appears. It rises together with that result's `out_valid` pulse and then stays 1 until reset.
- R5: `out_valid` is 1 exactly LATENCY cycles after each rising edge at which `in_valid` was 1, and 0 otherwise. LATENCY is 1 when PIPE_SPLIT = 0 and 2 when PIPE_SPLIT = 1.
- R6: A cycle with `in_valid` low is ignored. `in_sample` is not stored, the window does not move, and `out_avg` and `out_full` keep their values.
- R7: With SAMPLE_W-bit two's-complement samples, a window filled with the most negative value yields exactly -2^(SAMPLE_W-1), and one filled with the most positive value yields 2^(SAMPLE_W-1)-1. Neither wraps.
- R8: Samples may be accepted on every consecutive cycle in both adder variants. The two variants produce identical result sequences, offset only by their latency.
- R9: The (N+1)-th accepted sample evicts the first one. From then on each accepted sample replaces the oldest sample still in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_sample` at this edge |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| out_valid | output | 1 | One-cycle pulse marking a new average |
| out_avg | output | SAMPLE_W | Signed window mean, held between pulses |
| out_full | output | 1 | Window holds N real samples |

## Verification
The properties assume that `rst` is held high for at least two rising edges before `in_valid` is ever asserted. The latency and hold properties also assume that `rst` does not fall with a result still in flight. The stimulus keeps to this: every reset spans several edges, and the mid-stream reset is raised only after idle cycles have drained the pipeline. Within those limits, `in_valid` and `in_sample` may take any value on any cycle. The stimulus covers solid bursts, isolated pulses, long idle gaps and full-scale values of both signs.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

   // Width of a running total that can hold 2^lg samples of sw bits each.
   function automatic int total_width(input int sw, input int lg);
      return sw + lg;
   endfunction

   // Cycles from an accepted sample to its result.
   function automatic int result_latency(input bit split);
      return split ? 2 : 1;
   endfunction

   localparam int MAX_LOG2_DEPTH = 12;
   localparam int MIN_SAMPLE_W   = 2;

endpackage

// File: rtl/mavg_ring.sv
module mavg_ring #(
   parameter int SAMPLE_W   = 16,
   parameter int LOG2_DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic signed [SAMPLE_W-1:0] wr_data,
   output logic signed [SAMPLE_W-1:0] evict_data,
   output logic                       fill_now
);
   localparam int DEPTH = 1 << LOG2_DEPTH;

   logic signed [SAMPLE_W-1:0] slot_q [DEPTH];
   logic [LOG2_DEPTH-1:0]      head_q;
   logic                       seen_all_q;

   // Read-before-write: old contents of the head slot are visible this cycle.
   assign evict_data = slot_q[head_q];
   assign fill_now   = seen_all_q | (&head_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      end else if (wr_en) begin
         slot_q[head_q] <= wr_data;
      end
   end

   // Head pointer wraps naturally since DEPTH is a power of two.
   always_ff @(posedge clk) begin
      if (rst) begin
         head_q     <= '0;
         seen_all_q <= 1'b0;
      end else if (wr_en) begin
         head_q     <= head_q + LOG2_DEPTH'(1);
         seen_all_q <= seen_all_q | (&head_q);
      end
   end

endmodule

// File: rtl/mavg_accum.sv
module mavg_accum #(
   parameter int SAMPLE_W   = 16,
   parameter int LOG2_DEPTH = 4,
   parameter bit PIPE_SPLIT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       acc_en,
   input  logic signed [SAMPLE_W-1:0] new_s,
   input  logic signed [SAMPLE_W-1:0] old_s,
   input  logic                       fill_in,
   output logic                       res_valid,
   output logic signed [SAMPLE_W-1:0] res_avg,
   output logic                       res_full
);
   localparam int TOT_W  = mavg_pkg::total_width(SAMPLE_W, LOG2_DEPTH);
   localparam int DIFF_W = SAMPLE_W + 1;

   logic signed [TOT_W-1:0] total_q;

   generate
      if (PIPE_SPLIT == 1'b0) begin : g_single
         logic signed [TOT_W-1:0]    new_ext, old_ext, nxt_total;
         logic                       v_q, f_q;
         logic signed [SAMPLE_W-1:0] a_q;

         assign new_ext   = {{LOG2_DEPTH{new_s[SAMPLE_W-1]}}, new_s};
         assign old_ext   = {{LOG2_DEPTH{old_s[SAMPLE_W-1]}}, old_s};
         assign nxt_total = total_q + new_ext - old_ext;

         always_ff @(posedge clk) begin
            if (rst) begin
               total_q <= '0;
               v_q     <= 1'b0;
               a_q     <= '0;
               f_q     <= 1'b0;
            end else begin
               v_q <= acc_en;
               if (acc_en) begin
                  total_q <= nxt_total;
                  a_q     <= nxt_total[TOT_W-1:LOG2_DEPTH];
                  f_q     <= fill_in;
               end
            end
         end

         assign res_valid = v_q;
         assign res_avg   = a_q;
         assign res_full  = f_q;
      end else begin : g_split
         // Stage 1: difference new - old (two-input subtract).
         logic signed [DIFF_W-1:0]   diff_q;
         logic                       s1_v_q, s1_f_q;
         // Stage 2: total + difference (two-input add).
         logic signed [TOT_W-1:0]    diff_ext, nxt_total;
         logic                       v_q, f_q;
         logic signed [SAMPLE_W-1:0] a_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               diff_q <= '0;
               s1_v_q <= 1'b0;
               s1_f_q <= 1'b0;
            end else begin
               s1_v_q <= acc_en;
               if (acc_en) begin
                  diff_q <= {new_s[SAMPLE_W-1], new_s} - {old_s[SAMPLE_W-1], old_s};
                  s1_f_q <= fill_in;
               end
            end
         end

         assign diff_ext  = {{(TOT_W-DIFF_W){diff_q[DIFF_W-1]}}, diff_q};
         assign nxt_total = total_q + diff_ext;

         always_ff @(posedge clk) begin
            if (rst) begin
               total_q <= '0;
               v_q     <= 1'b0;
               a_q     <= '0;
               f_q     <= 1'b0;
            end else begin
               v_q <= s1_v_q;
               if (s1_v_q) begin
                  total_q <= nxt_total;
                  a_q     <= nxt_total[TOT_W-1:LOG2_DEPTH];
                  f_q     <= s1_f_q;
               end
            end
         end

         assign res_valid = v_q;
         assign res_avg   = a_q;
         assign res_full  = f_q;
      end
   endgenerate

endmodule

// File: rtl/mavg_filter.sv
module mavg_filter #(
   parameter int SAMPLE_W   = 16,
   parameter int LOG2_DEPTH = 4,
   parameter bit PIPE_SPLIT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_avg,
   output logic                       out_full
);
   generate
      if (LOG2_DEPTH < 1 || LOG2_DEPTH > mavg_pkg::MAX_LOG2_DEPTH) begin : g_bad_depth
         $error("mavg_filter: LOG2_DEPTH out of range");
      end
      if (SAMPLE_W < mavg_pkg::MIN_SAMPLE_W) begin : g_bad_width
         $error("mavg_filter: SAMPLE_W too small");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] evicted;
   logic                       fill_now;

   mavg_ring #(
      .SAMPLE_W  (SAMPLE_W),
      .LOG2_DEPTH(LOG2_DEPTH)
   ) u_ring (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (in_valid),
      .wr_data   (in_sample),
      .evict_data(evicted),
      .fill_now  (fill_now)
   );

   mavg_accum #(
      .SAMPLE_W  (SAMPLE_W),
      .LOG2_DEPTH(LOG2_DEPTH),
      .PIPE_SPLIT(PIPE_SPLIT)
   ) u_acc (
      .clk      (clk),
      .rst      (rst),
      .acc_en   (in_valid),
      .new_s    (in_sample),
      .old_s    (evicted),
      .fill_in  (fill_now),
      .res_valid(out_valid),
      .res_avg  (out_avg),
      .res_full (out_full)
   );

endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk #(
   parameter int SAMPLE_W   = 16,
   parameter bit PIPE_SPLIT = 1'b0
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_avg,
   input logic                out_full
);
   // R1: the first cycle after reset shows cleared outputs.
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_avg == '0 && !out_full && !out_valid));

   // R4: full never drops without reset, and rises only with a result.
   assert_full_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      out_full |=> out_full);
   assert_full_rises_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(out_full) |-> out_valid);

   // R6: outputs hold between result pulses.
   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_avg) && $stable(out_full)));

   // R5: result pulse follows each accepted sample after the fixed latency.
   generate
      if (PIPE_SPLIT == 1'b0) begin : g_lat1
         assert_valid_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
         assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
      end else begin : g_lat2
         assert_valid_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> ##1 out_valid);
         assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ##1 !out_valid);
      end
   endgenerate

endmodule

bind mavg_filter mavg_filter_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .PIPE_SPLIT(PIPE_SPLIT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .out_valid(out_valid),
   .out_avg  (out_avg),
   .out_full (out_full)
);

// File: tb/mavg_filter_test.sv
`timescale 1ns/1ps
module mavg_filter_test;
   localparam int W   = 8;
   localparam int LG  = 2;
   localparam int N   = 1 << LG;
   localparam realtime HALF = 10.0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [W-1:0] s_in = '0;

   logic                v1, f1, v2, f2;
   logic signed [W-1:0] a1, a2;

   always #(HALF) clk = ~clk;

   mavg_filter #(.SAMPLE_W(W), .LOG2_DEPTH(LG), .PIPE_SPLIT(1'b0)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(s_in),
      .out_valid(v1), .out_avg(a1), .out_full(f1));

   mavg_filter #(.SAMPLE_W(W), .LOG2_DEPTH(LG), .PIPE_SPLIT(1'b1)) uut_p (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(s_in),
      .out_valid(v2), .out_avg(a2), .out_full(f2));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Behavioural reference
   int win[$];
   int sum, cnt;
   int e1_v, e1_a, e1_f;
   int e2_v, e2_a, e2_f;
   int p_v, p_a, p_f;
   int unsigned seed = 32'h1234_5678;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      win.delete();
      for (int k = 0; k < N; k++) win.push_back(0);
      sum = 0; cnt = 0;
      e1_v = 0; e1_a = 0; e1_f = 0;
      e2_v = 0; e2_a = 0; e2_f = 0;
      p_v = 0; p_a = 0; p_f = 0;
   endtask

   task automatic step(input bit r, input bit v, input int s, input string tag);
      int ca, cf, old;
      ca = 0; cf = 0;
      rst = r; in_valid = v; s_in = W'(s);
      if (r) begin
         model_clear();
      end else begin
         if (v) begin
            old = win.pop_front();
            win.push_back(s);
            sum = sum + s - old;
            cnt++;
            ca = sum >>> LG;
            cf = (cnt >= N) ? 1 : 0;
         end
         e1_v = v;
         if (v) begin e1_a = ca; e1_f = cf; end
         e2_v = p_v;
         if (p_v != 0) begin e2_a = p_a; e2_f = p_f; end
         p_v = v;
         if (v) begin p_a = ca; p_f = cf; end
      end
      @(negedge clk);
      chk(r ? "R1" : "R5", "valid", int'(v1), e1_v);
      chk(r ? "R1" : (e1_v != 0 ? tag : "R6"), "avg", int'(a1), e1_a);
      chk(r ? "R1" : "R4", "full", int'(f1), e1_f);
      chk(r ? "R1" : "R5", "valid_split", int'(v2), e2_v);
      chk(r ? "R1" : (e2_v != 0 ? "R8" : "R6"), "avg_split", int'(a2), e2_a);
      chk(r ? "R1" : "R4", "full_split", int'(f2), e2_f);
   endtask

   function automatic int next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'hFF) - 128;
   endfunction

   initial begin
      model_clear();
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
      // R3: partial window, zero padded
      step(0, 1, 10, "R3");
      step(0, 1, 20, "R3");
      step(0, 1, 30, "R3");
      // R4: N-th sample fills the window
      step(0, 1, 40, "R4");
      // R9: wrap, oldest evicted
      step(0, 1, 50, "R9");
      step(0, 1, -60, "R9");
      // R6: idle cycles with changing data are ignored
      step(0, 0, 99, "R6");
      step(0, 0, -99, "R6");
      step(0, 0, 77, "R6");
      step(0, 1, 3, "R9");
      step(0, 0, 5, "R6");
      step(0, 1, 7, "R9");
      // R2: floor rounding on negative sums
      for (int i = 0; i < N; i++) step(0, 1, 0, "R2");
      step(0, 1, -1, "R2");
      step(0, 1, -2, "R2");
      step(0, 1, 5, "R2");
      step(0, 1, -7, "R2");
      // R7: full-scale windows
      for (int i = 0; i < N + 2; i++) step(0, 1, -128, "R7");
      for (int i = 0; i < N + 2; i++) step(0, 1, 127, "R7");
      for (int i = 0; i < 2 * N; i++) step(0, 1, (i % 2) ? 127 : -128, "R7");
      // R8: dense random stream and sparse random stream
      for (int i = 0; i < 60; i++) step(0, 1, next_rand(), "R2");
      for (int i = 0; i < 60; i++) step(0, (next_rand() > 0) ? 1'b1 : 1'b0, next_rand(), "R2");
      // drain, then mid-stream reset; R1: buffer contents cleared
      step(0, 0, 0, "R6");
      step(0, 0, 0, "R6");
      for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
      step(0, 1, 8, "R1");
      step(0, 1, 8, "R3");
      step(0, 1, 8, "R3");
      step(0, 1, 8, "R4");
      step(0, 0, 0, "R6");
      step(0, 0, 0, "R6");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(HALF * 2 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule